// File: doc/BRIEF.md
# Four-Bank SDRAM Command Timing Checker

This block watches the command pins of a four-bank synchronous DRAM on every clock and keeps, for each bank, whether it is open, which row it holds, how many cycles have passed since it was last activated and since it last began precharging, and whether an automatic precharge is pending. Against that state it judges every activate, read, write and precharge, and raises a one-cycle pulse on a separate output bit for each timing or protocol rule that the command breaks. A sticky copy of all pulses is kept until a clear input wipes it.

All timing limits are parameters counted in clock cycles. A burst-length code input tells the checker how long each read or write burst lasts, so that it can place the internal precharge that follows a read or write issued with the auto-precharge bit set. Refresh, mode-register, burst-stop and clock-enable traffic is not judged.

Command encoding with chip select low, as {ras_n, cas_n, we_n}: activate 011, read 101, write 100, precharge 010; anything else, or chip select high, is treated as no command. The top address bit (addr[10] by default) is the auto-precharge / all-banks bit; `ba` selects the bank. Burst-length codes: 0 = 1 beat, 1 = 2, 2 = 4, 3 = 8, 4..7 = full page (PAGE_COLS beats).

Top module: `sdram_bank_rule_checker`

## Requirements
- R1: A read or write to a bank that is not open sets viol[0] in the cycle after the command.
- R2: A read or write to an open bank fewer than TRCD cycles after that bank's activate sets viol[1]; at TRCD or more it does not.
- R3: An activate to a bank that is already open sets viol[2] and leaves the bank's state unchanged; an activate to a closed bank fewer than TRC cycles after that bank's previous activate sets viol[3].
- R4: An activate fewer than TRRD cycles after an activate to a different bank sets viol[4].
- R5: An activate to a closed bank fewer than TRP cycles after that bank began precharging sets viol[5].
- R6: A precharge with the top address bit low closes only the bank selected by `ba`; with that bit high it closes every open bank.
- R7: A read with the top address bit set closes its bank after the burst's beat count of cycles; a write with it set closes the bank TDPL cycles after its last data beat, so reactivation earlier than TDPL+TRP cycles after the last beat sets viol[5].
- R8: While an automatic precharge is pending on a bank, a read, write or precharge that targets that bank sets viol[6] and does not disturb the pending precharge.
- R9: When an automatic precharge begins fewer than TRAS cycles after the bank's activate, viol[7] pulses in the cycle after it begins.
- R10: A read or write with the top address bit set while the burst-length code selects full page sets viol[8] and schedules no automatic precharge.
- R11: Each viol bit is a single-cycle pulse; err_sticky collects every pulse, is cleared by `clr`, and a violation in the same cycle as `clr` survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low to issue a command |
| ras_n | input | 1 | Row strobe pin of the command |
| cas_n | input | 1 | Column strobe pin of the command |
| we_n | input | 1 | Write-enable pin of the command |
| ba | input | BA_W (2) | Bank select |
| addr | input | ROW_W (11) | Row address on activate; top bit is the auto-precharge / all-banks bit |
| bl_code | input | 3 | Burst-length code |
| clr | input | 1 | Clears err_sticky |
| viol | output | 9 | One-cycle violation pulses, one bit per rule |
| err_sticky | output | 9 | Accumulated violations |
| bank_open | output | NUM_BANKS (4) | Per-bank open flag |
| bank_ap | output | NUM_BANKS (4) | Per-bank pending automatic precharge |
| bank_row | output | NUM_BANKS*ROW_W (44) | Open row of each bank, bank 0 in the low bits |

## Verification
A wrong open flag shows on the very next command to that bank: a legal read is reported as a closed-bank access, or a second activate slips through unflagged, one cycle after the command edge. A miscounted elapsed-cycle counter or auto-precharge countdown shows as a pulse appearing or missing exactly at the boundary cycle of tRCD, tRC, tRP or tRAS, or as bank_open falling one cycle early or late after a read or write with auto-precharge. The bench therefore issues commands on the exact boundary cycles and compares every cycle's viol vector in order against an expected queue.

// File: rtl/sdrchk_pkg.sv
package sdrchk_pkg;

  typedef enum logic [2:0] {OP_NONE, OP_ACT, OP_RD, OP_WR, OP_PRE} op_t;

  localparam int NRULE    = 9;
  localparam int V_CLOSED = 0;
  localparam int V_RCD    = 1;
  localparam int V_REOPEN = 2;
  localparam int V_RC     = 3;
  localparam int V_RRD    = 4;
  localparam int V_RP     = 5;
  localparam int V_APBUSY = 6;
  localparam int V_RAS    = 7;
  localparam int V_APFULL = 8;

  // beats in one burst for a burst-length code
  function automatic int burst_beats(input logic [2:0] code, input int page);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      default: return page;
    endcase
  endfunction

  function automatic logic is_full_page(input logic [2:0] code);
    return code > 3'd3;
  endfunction

  // cycles from the read/write command edge to the internal precharge edge
  function automatic int ap_delay(input logic is_wr, input logic [2:0] code,
                                  input int page, input int tdpl);
    int n;
    n = burst_beats(code, page);
    return is_wr ? (n - 1 + tdpl) : n;
  endfunction

endpackage

// File: rtl/sdrchk_decode.sv
module sdrchk_decode
  import sdrchk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output op_t  op
);
  always_comb begin
    op = OP_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  op = OP_ACT;
        3'b101:  op = OP_RD;
        3'b100:  op = OP_WR;
        3'b010:  op = OP_PRE;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdrchk_bank.sv
module sdrchk_bank
  import sdrchk_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int PAGE_COLS = 256,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRC       = 9,
  parameter int TRAS      = 6,
  parameter int TDPL      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_t               op,
  input  logic              hit,
  input  logic              pre_all,
  input  logic              a10,
  input  logic [ROW_W-1:0]  row,
  input  logic [2:0]        bl_code,
  output logic              is_open,
  output logic              ap_pend,
  output logic [ROW_W-1:0]  row_q,
  output logic [NRULE-1:0]  rule_hit
);
  localparam int TMAX  = (TRC > TRAS ? TRC : TRAS) > (TRCD > TRP ? TRCD : TRP)
                       ? (TRC > TRAS ? TRC : TRAS) : (TRCD > TRP ? TRCD : TRP);
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int AP_W  = $clog2(PAGE_COLS + TDPL + 1);
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(TMAX);
  localparam logic [CNT_W-1:0] L_TRCD = CNT_W'(TRCD);
  localparam logic [CNT_W-1:0] L_TRP  = CNT_W'(TRP);
  localparam logic [CNT_W-1:0] L_TRC  = CNT_W'(TRC);
  localparam logic [CNT_W-1:0] L_TRAS = CNT_W'(TRAS);

  logic [CNT_W-1:0] since_act, since_pre;
  logic [AP_W-1:0]  ap_cnt;

  // named internal events
  logic is_rw, is_act, is_pre, rw_ok, act_ok, pre_ok, ap_sched, ap_fire;
  assign is_rw    = hit && (op == OP_RD || op == OP_WR);
  assign is_act   = hit && (op == OP_ACT);
  assign is_pre   = (op == OP_PRE) && (hit || pre_all);
  assign rw_ok    = is_rw && is_open && !ap_pend;
  assign act_ok   = is_act && !is_open;
  assign pre_ok   = is_pre && is_open && !ap_pend;
  assign ap_sched = rw_ok && a10 && !is_full_page(bl_code);
  assign ap_fire  = ap_pend && (ap_cnt == AP_W'(1));

  always_comb begin
    rule_hit           = '0;
    rule_hit[V_CLOSED] = is_rw && !is_open;
    rule_hit[V_RCD]    = rw_ok && (since_act < L_TRCD);
    rule_hit[V_REOPEN] = is_act && is_open;
    rule_hit[V_RC]     = act_ok && (since_act < L_TRC);
    rule_hit[V_RP]     = act_ok && (since_pre < L_TRP);
    rule_hit[V_APBUSY] = ap_pend && (is_rw || is_pre);
    rule_hit[V_RAS]    = ap_fire && (since_act < L_TRAS);
    rule_hit[V_APFULL] = is_rw && a10 && is_full_page(bl_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open   <= 1'b0;
      ap_pend   <= 1'b0;
      ap_cnt    <= '0;
      row_q     <= '0;
      since_act <= SAT;
      since_pre <= SAT;
    end else begin
      if (act_ok)                 since_act <= CNT_W'(1);
      else if (since_act != SAT)  since_act <= since_act + CNT_W'(1);

      if (pre_ok || ap_fire)      since_pre <= CNT_W'(1);
      else if (since_pre != SAT)  since_pre <= since_pre + CNT_W'(1);

      if (ap_fire || pre_ok)      is_open <= 1'b0;
      else if (act_ok)            is_open <= 1'b1;

      if (act_ok)                 row_q <= row;

      if (ap_fire)                ap_pend <= 1'b0;
      else if (ap_sched)          ap_pend <= 1'b1;

      if (ap_sched)
        ap_cnt <= AP_W'(ap_delay(op == OP_WR, bl_code, PAGE_COLS, TDPL));
      else if (ap_pend)
        ap_cnt <= ap_cnt - AP_W'(1);
    end
  end
endmodule

// File: rtl/sdram_bank_rule_checker.sv
module sdram_bank_rule_checker
  import sdrchk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int PAGE_COLS = 256,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRC       = 9,
  parameter int TRAS      = 6,
  parameter int TRRD      = 2,
  parameter int TDPL      = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  input  logic [2:0]                 bl_code,
  input  logic                       clr,
  output logic [NRULE-1:0]           viol,
  output logic [NRULE-1:0]           err_sticky,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS-1:0]       bank_ap,
  output logic [NUM_BANKS*ROW_W-1:0] bank_row
);
  localparam int RRD_W = $clog2(TRRD + 1);
  localparam logic [RRD_W-1:0] L_RRD = RRD_W'(TRRD);

  op_t              op;
  logic             a10, pre_all, rrd_hit;
  logic [RRD_W-1:0] since_any_act;
  logic [BA_W-1:0]  last_act_ba;
  logic [NRULE-1:0] bank_rules [NUM_BANKS];
  logic [NRULE-1:0] rules_comb;

  assign a10     = addr[ROW_W-1];
  assign pre_all = (op == OP_PRE) && a10;
  assign rrd_hit = (op == OP_ACT) && (ba != last_act_ba) && (since_any_act < L_RRD);

  sdrchk_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .op(op)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdrchk_bank #(
      .ROW_W(ROW_W), .PAGE_COLS(PAGE_COLS), .TRCD(TRCD), .TRP(TRP),
      .TRC(TRC), .TRAS(TRAS), .TDPL(TDPL)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .hit     (ba == BA_W'(b)),
      .pre_all (pre_all),
      .a10     (a10),
      .row     (addr),
      .bl_code (bl_code),
      .is_open (bank_open[b]),
      .ap_pend (bank_ap[b]),
      .row_q   (bank_row[b*ROW_W +: ROW_W]),
      .rule_hit(bank_rules[b])
    );
  end

  always_comb begin
    rules_comb = '0;
    for (int b = 0; b < NUM_BANKS; b++) rules_comb |= bank_rules[b];
    rules_comb[V_RRD] = rrd_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_any_act <= L_RRD;
      last_act_ba   <= '0;
      viol          <= '0;
      err_sticky    <= '0;
    end else begin
      if (op == OP_ACT) begin
        since_any_act <= RRD_W'(1);
        last_act_ba   <= ba;
      end else if (since_any_act != L_RRD) begin
        since_any_act <= since_any_act + RRD_W'(1);
      end
      viol       <= rules_comb;
      err_sticky <= (clr ? '0 : err_sticky) | rules_comb;
    end
  end
endmodule

// File: rtl/sdrchk_props.sv
module sdrchk_props
  import sdrchk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic [ROW_W-1:0]     addr,
  input logic [2:0]           bl_code,
  input logic                 clr,
  input logic [NRULE-1:0]     viol,
  input logic [NRULE-1:0]     err_sticky,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] bank_ap
);
  logic rw_pin, pre_pin;
  assign rw_pin  = !cs_n && ras_n && !cas_n;
  assign pre_pin = !cs_n && !ras_n && cas_n && !we_n;

  assert_closed_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_pin && !bank_open[ba]) |=> viol[V_CLOSED]);

  assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_pin && addr[ROW_W-1] && bank_ap == '0) |=> bank_open == '0);

  assert_ap_implies_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ap & ~bank_open) == '0);

  assert_ap_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_pin && bank_ap[ba]) |=> viol[V_APBUSY]);

  assert_ap_full_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_pin && addr[ROW_W-1] && bl_code > 3'd3) |=> viol[V_APFULL]);

  assert_sticky_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol & ~err_sticky) == '0);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && viol == '0) |-> err_sticky == '0);
endmodule

bind sdram_bank_rule_checker sdrchk_props #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W)
) u_props (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .bl_code(bl_code), .clr(clr),
  .viol(viol), .err_sticky(err_sticky), .bank_open(bank_open), .bank_ap(bank_ap)
);

// File: tb/sdram_bank_rule_checker_test.sv
`timescale 1ns/1ps
module sdram_bank_rule_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [2:0]  bl_code = 3'd2;
  logic        clr = 1'b0;
  logic [8:0]  viol, err_sticky;
  logic [3:0]  bank_open, bank_ap;
  logic [43:0] bank_row;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  // command codes of the bench
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4;

  always #2.5 clk = ~clk;

  sdram_bank_rule_checker uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bl_code(bl_code), .clr(clr),
    .viol(viol), .err_sticky(err_sticky), .bank_open(bank_open),
    .bank_ap(bank_ap), .bank_row(bank_row)
  );

  task automatic check(input logic [43:0] act, input logic [43:0] expv, input string tag);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // driver: one command per cycle, expected viol vector queued for the monitor
  task automatic step(input int cmd, input int b, input bit ap, input int row,
                      input bit c, input logic [8:0] expv, input string tag);
    ba  = 2'(b);
    clr = c;
    case (cmd)
      ACT:     {ras_n, cas_n, we_n} = 3'b011;
      RD:      {ras_n, cas_n, we_n} = 3'b101;
      WR:      {ras_n, cas_n, we_n} = 3'b100;
      PRE:     {ras_n, cas_n, we_n} = 3'b010;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    addr = (cmd == ACT) ? 11'(row) : {ap, 10'h000};
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(NOP, 0, 0, 0, 0, 9'h000, "idle");
  endtask

  // monitor: viol is registered at the edge that samples the queued command
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(44'(viol), 44'(exp_q.pop_front()), tag_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(44'(viol), 44'h0, "reset viol R11");
    check(44'(err_sticky), 44'h0, "reset sticky R11");
    check(44'(bank_open), 44'h0, "reset bank_open R1");

    step(RD,  0, 0, 0,   0, 9'h001, "R1 read to closed bank");
    step(ACT, 0, 0, 5,   0, 9'h000, "R1 activate");
    step(RD,  0, 0, 0,   0, 9'h002, "R2 read one cycle after activate");
    step(ACT, 1, 0, 7,   0, 9'h000, "R4 activate at tRRD");
    step(ACT, 2, 0, 9,   0, 9'h010, "R4 activate under tRRD");
    step(WR,  0, 0, 0,   0, 9'h000, "R2 write after tRCD");
    check(44'(bank_open), 44'h7, "R3 banks 0..2 open");
    check(bank_row[10:0], 44'h5, "R3 row of bank 0");
    step(ACT, 0, 0, 3,   0, 9'h004, "R3 activate of open bank");
    check(bank_row[10:0], 44'h5, "R3 row unchanged");
    step(PRE, 0, 0, 0,   0, 9'h000, "R6 single precharge");
    check(44'(bank_open), 44'h6, "R6 only bank 0 closed");
    step(ACT, 0, 0, 5,   0, 9'h028, "R5 R3 activate under tRP and tRC");
    step(PRE, 2, 1, 0,   0, 9'h000, "R6 precharge all");
    check(44'(bank_open), 44'h0, "R6 all banks closed");

    // read with auto-precharge, 2 beats
    bl_code = 3'd1;
    step(ACT, 3, 0, 3,   0, 9'h000, "R7 activate bank 3");
    nops(6);
    step(RD,  3, 1, 0,   0, 9'h000, "R7 read with auto-precharge");
    step(RD,  3, 0, 0,   0, 9'h040, "R8 read during auto-precharge");
    check(44'(bank_open[3]), 44'h1, "R7 bank 3 still open");
    step(NOP, 0, 0, 0,   0, 9'h000, "R9 tRAS met");
    check(44'(bank_open[3]), 44'h0, "R7 read auto-precharge closed bank");
    step(ACT, 3, 0, 4,   0, 9'h020, "R7 activate too soon after auto-precharge");

    // write with auto-precharge, 4 beats
    bl_code = 3'd2;
    nops(2);
    step(WR,  3, 1, 0,   0, 9'h000, "R7 write with auto-precharge");
    nops(4);
    check(44'(bank_open[3]), 44'h1, "R7 open through write recovery");
    nops(1);
    check(44'(bank_open[3]), 44'h0, "R7 closed after write recovery");
    nops(1);
    step(ACT, 3, 0, 6,   0, 9'h020, "R7 activate before tDAL");

    // tRAS violation by short auto-precharge read
    bl_code = 3'd0;
    nops(1);
    step(ACT, 1, 0, 1,   0, 9'h000, "R9 activate bank 1");
    nops(2);
    step(RD,  1, 1, 0,   0, 9'h000, "R9 one-beat auto-precharge read");
    step(NOP, 0, 0, 0,   0, 9'h080, "R9 precharge before tRAS");
    check(44'(bank_open[1]), 44'h0, "R9 bank 1 closed");

    // full page with auto-precharge
    bl_code = 3'd7;
    step(ACT, 2, 0, 2,   0, 9'h000, "R10 activate bank 2");
    nops(2);
    step(RD,  2, 1, 0,   0, 9'h100, "R10 full-page auto-precharge");
    step(NOP, 0, 0, 0,   0, 9'h000, "R10 no pulse after");
    check(44'(bank_ap[2]), 44'h0, "R10 nothing scheduled");
    check(44'(bank_open[2]), 44'h1, "R10 bank stays open");
    step(WR,  2, 0, 0,   0, 9'h000, "R10 bank not busy");

    check(44'(err_sticky), 44'h1FF, "R11 sticky holds all rules");
    step(NOP, 0, 0, 0,   1, 9'h000, "R11 clear cycle");
    check(44'(err_sticky), 44'h0, "R11 cleared");
    step(RD,  0, 0, 0,   1, 9'h001, "R11 clear with violation");
    check(44'(err_sticky), 44'h1, "R11 violation survives clear");
    nops(2);
    check(44'(err_sticky), 44'h1, "R11 sticky kept");
    repeat (2) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule